// File: doc/BRIEF.md
# Two-Way Host/Coprocessor Message Mailbox

This block is the meeting point between a host processor and one coprocessor. It holds two word FIFOs. The inbound FIFO carries words from the host to the coprocessor, and the outbound FIFO carries words from the coprocessor to the host. On the host side there is a small 32-bit register bus with an address, separate read and write strobes, write data and registered read data. On the coprocessor side each direction is a valid/ready stream.

Every message is two consecutive words. The host writes and reads both words through one data address. A write to that address pushes into the inbound FIFO, and a read from it pops from the outbound FIFO. A status register reports the FIFO flags, the pending interrupt and two sticky error bits. A control register holds the interrupt enable. That enable can only be changed by a write that also sets a companion write-enable bit. The interrupt is a level that stays high for as long as outbound words wait and the enable is set. The identifier byte of the message at the outbound head is also presented on its own output, so that it can be decoded without a bus read.

Top module: `duplex_mailbox`

## Requirements
- R1: A host write (hostWrEn=1) to address 0x8 pushes hostWrData into the inbound FIFO when that FIFO is not full. The coprocessor sees the words on inValid/inData in write order, and a word leaves the FIFO on a cycle with inValid=1 and inReady=1.
- R2: On a cycle with outValid=1 and outReady=1, outData is pushed into the outbound FIFO. A host read (hostRdEn=1) of address 0x8 pops the head word. hostRdData shows the result of every read from the clock edge that ends the read cycle, and holds it until the next read.
- R3: A host write to address 0x8 while the inbound FIFO is full is discarded and sets the sticky overflow bit, status bit 5.
- R4: A host read of address 0x8 while the outbound FIFO is empty returns 0 and sets the sticky underflow bit, status bit 6.
- R5: A host write to address 0x0 clears status bit 5 if write-data bit 5 is 1, and clears status bit 6 if write-data bit 6 is 1. A 0 in either position leaves that bit unchanged.
- R6: Control register at 0x4. A write loads interrupt enable (bit 0) from write-data bit 0 only when write-data bit 1 is also 1; otherwise the enable keeps its value. A read returns the enable in bit 0 and 0 in all other bits, bit 1 included.
- R7: irq is 1 exactly when the interrupt enable is 1 and the outbound FIFO is non-empty. It stays 1 until the host has read out every outbound word.
- R8: Status register at 0x0 has these bits: 0 interrupt pending, 1 inbound empty, 2 inbound full, 3 outbound empty, 4 outbound full. The flags change at the clock edge of the push or pop that changes the fill level. Reads of unmapped addresses return 0.
- R9: msgIdValid is 1 when the outbound FIFO is non-empty and its head word is the first word of a two-word message, counting pops since reset. msgId then equals bits 31:24 of that head word.
- R10: After reset, both FIFOs are empty, the interrupt enable and both sticky bits are 0, irq is 0, and a status read returns 0x0000000A.
- R11: outReady is 0 exactly while the outbound FIFO holds DEPTH words (default 4). inValid is 1 exactly while the inbound FIFO is non-empty.
- R12: The two words of a message may arrive in separate accesses with any number of cycles between them, even when the FIFO fills after the first word. Their order is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 4 | Host register byte address |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Registered host read data |
| irq | output | 1 | Level interrupt: outbound data pending and enabled |
| inValid | output | 1 | Inbound stream word available |
| inData | output | 32 | Inbound stream word |
| inReady | input | 1 | Coprocessor takes inbound word |
| outValid | input | 1 | Outbound stream word offered |
| outData | input | 32 | Outbound stream word |
| outReady | output | 1 | Outbound FIFO has room |
| msgIdValid | output | 1 | Outbound head is a message's first word |
| msgId | output | 8 | Identifier byte of the outbound head word |

## Verification
Directed sequences come first. Each one exercises a single feature on its own: guarded and unguarded control writes, one message pushed and then drained under an enabled interrupt, inbound overflow with the coprocessor stalled, an outbound underflow read, and a message split across a full FIFO. These show whether each status flag, sticky bit and guard acts alone. A long phase with random inputs follows. It mixes coprocessor backpressure, bursts of outbound traffic and arbitrary host accesses. Push and pop therefore coincide at full and empty levels, and message parity drifts across many pops. A queue-based model is compared with every output on every cycle. This catches off-by-one flag timing and ordering errors that the directed cases cannot provoke.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int unsigned OFF_STAT = 0;
  localparam int unsigned OFF_CTRL = 4;
  localparam int unsigned OFF_DATA = 8;

  // status bit positions
  localparam int unsigned ST_IRQ   = 0;
  localparam int unsigned ST_IEMPT = 1;
  localparam int unsigned ST_IFULL = 2;
  localparam int unsigned ST_OEMPT = 3;
  localparam int unsigned ST_OFULL = 4;
  localparam int unsigned ST_OVF   = 5;
  localparam int unsigned ST_UNF   = 6;

  // control bit positions
  localparam int unsigned CT_EN = 0;
  localparam int unsigned CT_WE = 1;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_DATA = 2'd2,
    SEL_NONE = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic    inPush;
    logic    outPop;
    logic    rdLoad;
    rd_sel_e rdSel;
  } mbox_strobe_t;

  typedef struct packed {
    logic inEmpty;
    logic inFull;
    logic outEmpty;
    logic outFull;
  } mbox_flags_t;

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count, countNext;
  logic doPush, doPop;

  assign doPush   = push & ~full;
  assign doPop    = pop & ~empty;
  assign headData = store[rdPtr];

  always_comb begin
    countNext = count;
    if (doPush && !doPop) countNext = count + 1'b1;
    else if (doPop && !doPush) countNext = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      empty <= 1'b1;
      full  <= 1'b0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      count <= countNext;
      empty <= (countNext == '0);
      full  <= (countNext == CNT_W'(DEPTH));
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= pushData;
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  a_r3_full_push_keeps_full: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> full && $stable(wrPtr));
  a_r8_empty_matches_level: assert property (@(posedge clk) disable iff (!rstN)
    empty == (count == '0));
  a_r4_empty_pop_inert: assert property (@(posedge clk) disable iff (!rstN)
    (empty && pop) |=> $stable(rdPtr));
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbox_strobe_t      strobe,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [DATA_W-1:0] statusWord,
  input  logic [DATA_W-1:0] ctrlWord,
  output logic [DATA_W-1:0] hostRdData,
  output mbox_flags_t       flags,
  output logic [7:0]        headId,
  output logic              inValid,
  output logic [DATA_W-1:0] inData,
  input  logic              inReady,
  input  logic              outValid,
  input  logic [DATA_W-1:0] outData,
  output logic              outReady
);
  logic [DATA_W-1:0] outHead;
  logic inEmpty, inFull, outEmpty, outFull;

  mbox_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) uInbound (
    .clk(clk), .rstN(rstN),
    .push(strobe.inPush), .pushData(hostWrData),
    .pop(inReady), .headData(inData),
    .empty(inEmpty), .full(inFull)
  );

  mbox_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) uOutbound (
    .clk(clk), .rstN(rstN),
    .push(outValid), .pushData(outData),
    .pop(strobe.outPop), .headData(outHead),
    .empty(outEmpty), .full(outFull)
  );

  assign inValid  = ~inEmpty;
  assign outReady = ~outFull;
  assign headId   = outHead[DATA_W-1 -: 8];

  always_comb begin
    flags.inEmpty  = inEmpty;
    flags.inFull   = inFull;
    flags.outEmpty = outEmpty;
    flags.outFull  = outFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdData <= '0;
    end else if (strobe.rdLoad) begin
      unique case (strobe.rdSel)
        SEL_STAT: hostRdData <= statusWord;
        SEL_CTRL: hostRdData <= ctrlWord;
        SEL_DATA: hostRdData <= outEmpty ? '0 : outHead;
        default:  hostRdData <= '0;
      endcase
    end
  end

  a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdLoad && strobe.rdSel == SEL_DATA && outEmpty) |=> hostRdData == '0);
  a_r2_rd_data_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdLoad |=> $stable(hostRdData));
  a_r11_ready_tracks_room: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !strobe.outPop && outEmpty) |=> !outEmpty);
endmodule

// File: rtl/mbox_control.sv
module mbox_control
  import mbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic              wrEnBit,
  input  logic              wrWeBit,
  input  logic              wrClrOvf,
  input  logic              wrClrUnf,
  input  mbox_flags_t       flags,
  output mbox_strobe_t      strobe,
  output logic [DATA_W-1:0] statusWord,
  output logic [DATA_W-1:0] ctrlWord,
  output logic              irq,
  output logic              msgIdValid
);
  logic irqEn, ovfSticky, unfSticky, headFirst;
  logic isStat, isCtrl, isData;

  assign isStat = (hostAddr == ADDR_W'(OFF_STAT));
  assign isCtrl = (hostAddr == ADDR_W'(OFF_CTRL));
  assign isData = (hostAddr == ADDR_W'(OFF_DATA));

  always_comb begin
    strobe.inPush = hostWrEn & isData & ~flags.inFull;
    strobe.outPop = hostRdEn & isData & ~flags.outEmpty;
    strobe.rdLoad = hostRdEn;
    if (isStat)      strobe.rdSel = SEL_STAT;
    else if (isCtrl) strobe.rdSel = SEL_CTRL;
    else if (isData) strobe.rdSel = SEL_DATA;
    else             strobe.rdSel = SEL_NONE;
  end

  assign irq        = irqEn & ~flags.outEmpty;
  assign msgIdValid = ~flags.outEmpty & headFirst;

  always_comb begin
    statusWord           = '0;
    statusWord[ST_IRQ]   = irq;
    statusWord[ST_IEMPT] = flags.inEmpty;
    statusWord[ST_IFULL] = flags.inFull;
    statusWord[ST_OEMPT] = flags.outEmpty;
    statusWord[ST_OFULL] = flags.outFull;
    statusWord[ST_OVF]   = ovfSticky;
    statusWord[ST_UNF]   = unfSticky;
    ctrlWord             = '0;
    ctrlWord[CT_EN]      = irqEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn     <= 1'b0;
      ovfSticky <= 1'b0;
      unfSticky <= 1'b0;
      headFirst <= 1'b1;
    end else begin
      if (hostWrEn && isCtrl && wrWeBit) irqEn <= wrEnBit;
      if (hostWrEn && isData && flags.inFull) ovfSticky <= 1'b1;
      else if (hostWrEn && isStat && wrClrOvf) ovfSticky <= 1'b0;
      if (hostRdEn && isData && flags.outEmpty) unfSticky <= 1'b1;
      else if (hostWrEn && isStat && wrClrUnf) unfSticky <= 1'b0;
      if (strobe.outPop) headFirst <= ~headFirst;
    end
  end

  a_r7_irq_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !flags.outEmpty);
  a_r6_enable_guarded: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWrEn && isCtrl && wrWeBit) |=> $stable(ctrlWord));
  a_r3_overflow_sets: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && isData && flags.inFull) |=> statusWord[ST_OVF]);
  a_r4_underflow_sets: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && isData && flags.outEmpty) |=> statusWord[ST_UNF]);
  a_r5_clear_ovf: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && isStat && wrClrOvf) |=> !statusWord[ST_OVF]);
endmodule

// File: rtl/duplex_mailbox.sv
module duplex_mailbox
  import mbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  output logic              irq,
  output logic              inValid,
  output logic [DATA_W-1:0] inData,
  input  logic              inReady,
  input  logic              outValid,
  input  logic [DATA_W-1:0] outData,
  output logic              outReady,
  output logic              msgIdValid,
  output logic [7:0]        msgId
);
  mbox_strobe_t      strobe;
  mbox_flags_t       flags;
  logic [DATA_W-1:0] statusWord, ctrlWord;

  mbox_control #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .hostAddr(hostAddr), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .wrEnBit(hostWrData[CT_EN]), .wrWeBit(hostWrData[CT_WE]),
    .wrClrOvf(hostWrData[ST_OVF]), .wrClrUnf(hostWrData[ST_UNF]),
    .flags(flags), .strobe(strobe),
    .statusWord(statusWord), .ctrlWord(ctrlWord),
    .irq(irq), .msgIdValid(msgIdValid)
  );

  mbox_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .hostWrData(hostWrData),
    .statusWord(statusWord), .ctrlWord(ctrlWord),
    .hostRdData(hostRdData), .flags(flags), .headId(msgId),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outReady(outReady)
  );
endmodule

// File: tb/tb_duplex_mailbox.sv
module tb_duplex_mailbox;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic        hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic irq, inValid, outReady, msgIdValid;
  logic [31:0] inData;
  logic inReady = 1'b0, outValid = 1'b0;
  logic [31:0] outData = '0;
  logic [7:0] msgId;

  int tests = 0, fails = 0, cycles = 0;

  duplex_mailbox #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .irq(irq), .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outData(outData), .outReady(outReady),
    .msgIdValid(msgIdValid), .msgId(msgId)
  );

  always #4 clk = ~clk;

  // reference model
  logic [31:0] inQ[$];
  logic [31:0] outQ[$];
  bit mEn, mOvf, mUnf, mFirst;
  logic [31:0] mRd;

  function automatic logic [31:0] modelStatus();
    logic [31:0] s = '0;
    s[0] = mEn && outQ.size() > 0;
    s[1] = inQ.size() == 0;
    s[2] = inQ.size() == DEPTH;
    s[3] = outQ.size() == 0;
    s[4] = outQ.size() == DEPTH;
    s[5] = mOvf;
    s[6] = mUnf;
    return s;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inQ.delete(); outQ.delete();
      mEn = 0; mOvf = 0; mUnf = 0; mFirst = 1; mRd = '0;
    end else begin
      int inSz, outSz;
      logic [31:0] stat;
      inSz = inQ.size(); outSz = outQ.size(); stat = modelStatus();
      if (hostRdEn) begin
        case (hostAddr)
          4'h0: mRd = stat;
          4'h4: mRd = {31'b0, mEn};
          4'h8: if (outSz > 0) begin mRd = outQ.pop_front(); mFirst = !mFirst; end
                else begin mRd = '0; mUnf = 1; end
          default: mRd = '0;
        endcase
      end
      if (inReady && inSz > 0) void'(inQ.pop_front());
      if (hostWrEn) begin
        case (hostAddr)
          4'h0: begin
            if (hostWrData[5]) mOvf = 0;
            if (hostWrData[6] && !(hostRdEn && hostAddr == 4'h8)) mUnf = 0;
          end
          4'h4: if (hostWrData[1]) mEn = hostWrData[0];
          4'h8: if (inSz < DEPTH) inQ.push_back(hostWrData); else mOvf = 1;
          default: ;
        endcase
      end
      if (outValid && outSz < DEPTH) outQ.push_back(outData);
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    check(irq === (mEn && outQ.size() > 0), "R7 irq", {31'b0, irq}, {31'b0, mEn && outQ.size() > 0});
    check(inValid === (inQ.size() > 0), "R11 inValid", {31'b0, inValid}, {31'b0, inQ.size() > 0});
    check(outReady === (outQ.size() < DEPTH), "R11 outReady", {31'b0, outReady}, {31'b0, outQ.size() < DEPTH});
    if (inQ.size() > 0) check(inData === inQ[0], "R1 inData order", inData, inQ[0]);
    check(msgIdValid === (outQ.size() > 0 && mFirst), "R9 msgIdValid",
          {31'b0, msgIdValid}, {31'b0, outQ.size() > 0 && mFirst});
    if (outQ.size() > 0 && mFirst) check(msgId === outQ[0][31:24], "R9 msgId", {24'b0, msgId}, {24'b0, outQ[0][31:24]});
    check(hostRdData === mRd, "R2 hostRdData", hostRdData, mRd);
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic hostWrite(logic [3:0] a, logic [31:0] d);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    tick();
    hostWrEn = 1'b0;
  endtask

  task automatic hostRead(logic [3:0] a, output logic [31:0] d);
    hostAddr = a; hostRdEn = 1'b1;
    tick();
    hostRdEn = 1'b0;
    d = hostRdData;
  endtask

  task automatic coPush(logic [31:0] w);
    outValid = 1'b1; outData = w;
    tick();
    outValid = 1'b0;
  endtask

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1;
    check(irq === 1'b0 && inValid === 1'b0 && outReady === 1'b1, "R10 reset outputs",
          {29'b0, irq, inValid, outReady}, 32'h1);
    rstN = 1'b1;
    tick();
    hostRead(4'h0, r);
    check(r === 32'h0000_000A, "R10 reset status", r, 32'h0000_000A);

    // R6 guarded enable
    hostWrite(4'h4, 32'h1);
    hostRead(4'h4, r);
    check(r === 32'h0, "R6 enable without guard ignored", r, 32'h0);
    hostWrite(4'h4, 32'h3);
    hostRead(4'h4, r);
    check(r === 32'h1, "R6 guarded set, guard reads 0", r, 32'h1);
    hostWrite(4'h4, 32'h0);
    hostRead(4'h4, r);
    check(r === 32'h1, "R6 clear without guard ignored", r, 32'h1);

    // R7/R9/R2 one message
    coPush(32'hA5_001122);
    check(irq === 1'b1, "R7 irq after outbound push", {31'b0, irq}, 32'h1);
    check(msgIdValid === 1'b1 && msgId === 8'hA5, "R9 id byte", {23'b0, msgIdValid, msgId}, 32'h1A5);
    coPush(32'h3344_5566);
    hostRead(4'h8, r);
    check(r === 32'hA500_1122, "R2 first word", r, 32'hA500_1122);
    check(msgIdValid === 1'b0 && irq === 1'b1, "R9 second word not a header; R7 still high",
          {30'b0, msgIdValid, irq}, 32'h1);
    hostRead(4'h8, r);
    check(r === 32'h3344_5566, "R2 second word", r, 32'h3344_5566);
    check(irq === 1'b0, "R7 irq drops after drain", {31'b0, irq}, 32'h0);

    // R3 overflow with stalled coprocessor
    for (int i = 0; i < DEPTH + 1; i++) hostWrite(4'h8, 32'h100 + i);
    hostRead(4'h0, r);
    check(r === 32'h0000_002C, "R3 overflow and R8 inbound full flags", r, 32'h0000_002C);
    hostWrite(4'h0, 32'h0000_0040);
    hostRead(4'h0, r);
    check(r[5] === 1'b1, "R5 clear of other bit leaves overflow", r, 32'h2C);
    hostWrite(4'h0, 32'h0000_0020);
    hostRead(4'h0, r);
    check(r === 32'h0000_000C, "R5 overflow cleared", r, 32'h0000_000C);
    for (int i = 0; i < DEPTH; i++) begin
      check(inData === 32'h100 + i, "R1 inbound order", inData, 32'h100 + i);
      inReady = 1'b1; tick(); inReady = 1'b0;
    end
    check(inValid === 1'b0, "R3 discarded word never delivered", {31'b0, inValid}, 32'h0);

    // R4 underflow
    hostRead(4'h8, r);
    check(r === 32'h0, "R4 empty read returns 0", r, 32'h0);
    hostRead(4'h0, r);
    check(r[6] === 1'b1, "R4 underflow sticky set", r, 32'h4A);
    hostWrite(4'h0, 32'h0000_0040);
    hostRead(4'h0, r);
    check(r === 32'h0000_000A, "R5 underflow cleared", r, 32'h0000_000A);

    // R11/R8 outbound full
    for (int i = 0; i < DEPTH; i++) coPush(32'h5000_0000 + i);
    check(outReady === 1'b0, "R11 outReady low when full", {31'b0, outReady}, 32'h0);
    coPush(32'hDEAD_BEEF);
    hostRead(4'h0, r);
    check(r === 32'h0000_0013, "R8 outbound full status with irq", r, 32'h13);
    for (int i = 0; i < DEPTH; i++) begin
      hostRead(4'h8, r);
      check(r === 32'h5000_0000 + i, "R11 refused word absent", r, 32'h5000_0000 + i);
    end

    // R12 message split across full inbound
    for (int i = 0; i < DEPTH - 1; i++) hostWrite(4'h8, 32'h700 + i);
    hostWrite(4'h8, 32'h7E00_0001);
    check(inValid === 1'b1, "R12 fifo full after first word", {31'b0, inValid}, 32'h1);
    repeat (5) tick();
    inReady = 1'b1; tick(); inReady = 1'b0;
    hostWrite(4'h8, 32'h0000_0002);
    hostRead(4'h0, r);
    check(r[5] === 1'b0, "R12 no overflow for split message", r, 32'h4);
    for (int i = 0; i < DEPTH; i++) begin
      logic [31:0] e;
      e = (i < DEPTH - 2) ? 32'h701 + i : (i == DEPTH - 2 ? 32'h7E00_0001 : 32'h2);
      check(inData === e, "R12 split order kept", inData, e);
      inReady = 1'b1; tick(); inReady = 1'b0;
    end

    // random mixed traffic, checked on every cycle by the model
    for (int n = 0; n < 4000; n++) begin
      int op;
      inReady  = ($urandom_range(0, 2) != 0);
      outValid = ($urandom_range(0, 2) == 0);
      outData  = $urandom;
      op = $urandom_range(0, 9);
      hostWrEn = 1'b0; hostRdEn = 1'b0;
      hostWrData = $urandom;
      case (op)
        0, 1: begin hostAddr = 4'h8; hostWrEn = 1'b1; end
        2, 3, 4: begin hostAddr = 4'h8; hostRdEn = 1'b1; end
        5: begin hostAddr = 4'h0; hostRdEn = 1'b1; end
        6: begin hostAddr = 4'h4; hostWrEn = 1'b1; end
        7: begin hostAddr = 4'h0; hostWrEn = 1'b1; end
        8: begin hostAddr = 4'h4; hostRdEn = 1'b1; end
        default: begin hostAddr = 4'hC; hostRdEn = 1'b1; end
      endcase
      tick();
    end
    hostWrEn = 1'b0; hostRdEn = 1'b0; outValid = 1'b0; inReady = 1'b0;
    repeat (3) tick();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule